// File: doc/BRIEF.md
# Masked-Write DRAM Data Port Controller

This block is the random-access data port of a small dynamic memory with 4-bit words. It runs on a fast system clock and treats the four active-low strobes (row, column, write enable, output enable) as ordinary asynchronous inputs. Each strobe passes through a two-flop synchronizer. A strobe edge is found by comparing the synchronized level with its value one clock earlier.

The same four data pins carry two kinds of information. When the row strobe falls, the value on the pins is taken as a per-line write mask. Later in the row cycle, the pins carry write data or read data. A write fires once both the column strobe and the write enable are low, using the pin value present when the later of the two falls is seen. Only the lines whose mask bit is 1 are updated in a 16 x 16 array of 4-bit words. For a read, the stored word is driven onto the pins while the column strobe and output enable are both low. The pins go back to high impedance as soon as either of those strobes rises. The row address is registered on the row-strobe fall and the column address on the column-strobe fall.

Top module: `mdram_io_ctrl`

## Requirements
- R1: On each row-strobe fall, the value on `dq[3:0]` is stored as the write mask for that row cycle. Bit i of the mask governs data line `dq[i]`.
- R2: During a write, data line i of the addressed word takes the new value when mask bit i is 1. It keeps its old value when mask bit i is 0.
- R3: When a row cycle ends (row strobe rises), its mask is discarded and the mask returns to all ones. Each row cycle writes only with the mask it captured itself.
- R4: A write happens exactly once per column/write-enable pairing. It uses the `dq` value present when the later of the two falls (column strobe or write enable) is seen, whichever of the two falls first.
- R5: `dq` is driven, with `dq_drv_en` = 1, only while the row strobe, column strobe and output enable are low and the write enable is high. The value driven is the word stored at the addressed row and column.
- R6: The pins return to high impedance (`dq_drv_en` = 0) after whichever of the column strobe or output enable rises first, while the other is still low.
- R7: A write whose captured mask is 0000 leaves the addressed word unchanged.
- R8: After an output-enable fall on the pin, `dq_drv_en` is still 0 after two clock edges and is 1 after the third edge (two synchronizer flops plus one output register).
- R9: After reset, `dq_drv_en` is 0 and the mask is all ones.
- R10: The row address is taken at the row-strobe fall and the column address at the column-strobe fall. Later changes on `row_addr` or `col_addr` within the cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| row_addr | input | 4 | Row address, registered at row-strobe fall |
| col_addr | input | 4 | Column address, registered at column-strobe fall |
| dq | inout | 4 | Shared mask / write data / read data pins |
| dq_drv_en | output | 1 | High while the block drives `dq` |

## Verification
A corrupted mask register would show up as wrong bits in the next readback of the word that was written. A sweep over all sixteen mask values on fresh locations exposes a swapped or stuck bit within one write-read pair. Pins that are not released on time show up as `dq_drv_en` staying high one clock past the point at which the strobe rise has passed through the synchronizer. A wrong latch point for the column address or the data makes an exhaustive readback of all 256 words differ at the first location written with the other strobe order.

// File: rtl/mdram_pkg.sv
// Shared constants for the masked-write DRAM data port.
// Assumes the four strobes are carried as one vector in the order below.
package mdram_pkg;
    localparam int STB_N   = 4;
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_OE  = 3;
endpackage

// File: rtl/strobe_sync.sv
// Two-flop synchronizer per active-low strobe, plus a one-clock history flop.
// Output act is 1 while the strobe is asserted (low on the pin).
// Assumes strobes are held for at least a few clocks.
module strobe_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] act,
    output logic [N-1:0] act_d
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        logic s1, s2, s3;
        // Sample the inverted pin, align it to clk and keep the previous value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= ~strb_n[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign act[i]   = s2;
        assign act_d[i] = s3;
    end
endmodule

// File: rtl/row_ctrl.sv
// Row-cycle control: edge detection, mask capture, address registers,
// write trigger and the read-drive condition.
// Assumes the dq value is stable around the synchronized strobe edges.
module row_ctrl
    import mdram_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_N-1:0] act,
    input  logic [STB_N-1:0] act_d,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_eff,
    output logic [DQ_W-1:0]  mask_q,
    output logic             wr_en,
    output logic             drive_req
);
    logic             ras_fall, ras_rise, cas_fall, we_fall;
    logic [COL_W-1:0] col_q;

    // Edge flags from the current and previous synchronized levels.
    always_comb begin
        ras_fall = act[STB_RAS] & ~act_d[STB_RAS];
        ras_rise = ~act[STB_RAS] & act_d[STB_RAS];
        cas_fall = act[STB_CAS] & ~act_d[STB_CAS];
        we_fall  = act[STB_WE] & ~act_d[STB_WE];
    end

    // Write fires when the second of column strobe / write enable arrives.
    assign wr_en = act[STB_RAS] & act_d[STB_RAS] & act[STB_CAS] & act[STB_WE]
                 & (cas_fall | we_fall);

    // Read drive is requested while row, column and output enable are low, write high.
    assign drive_req = act[STB_RAS] & act[STB_CAS] & act[STB_OE] & ~act[STB_WE];

    // Column in use: live address on the column fall cycle, registered after.
    assign col_eff = cas_fall ? col_addr : col_q;

    // Mask register: load at row fall, back to all ones at row rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '1;
        else if (ras_fall) mask_q <= dq_in;
        else if (ras_rise) mask_q <= '1;
    end

    // Row and column address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (ras_fall) row_q <= row_addr;
            if (cas_fall) col_q <= col_addr;
        end
    end
endmodule

// File: rtl/word_array.sv
// Simple storage model with a per-bit write enable and combinational read.
// Assumes one write port and one read port; contents are not reset.
module word_array #(
    parameter int AW   = 8,
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [DQ_W-1:0] wr_mask,
    input  logic [AW-1:0]   addr,
    input  logic [DQ_W-1:0] wr_data,
    output logic [DQ_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < DQ_W; b++) begin : g_bit
        logic plane [DEPTH];
        // Update one bit plane when its mask bit permits it.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) plane[addr] <= wr_data[b];
        end
        assign rd_data[b] = plane[addr];
    end
endmodule

// File: rtl/mdram_io_ctrl.sv
// Top of the masked-write DRAM data port: synchronizes strobes, runs the
// row-cycle control, writes the array and drives the shared pins on reads.
// Assumes no external driver on dq while dq_drv_en is high.
module mdram_io_ctrl
    import mdram_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    inout  wire  [DQ_W-1:0]  dq,
    output logic             dq_drv_en
);
    localparam int AW = ROW_W + COL_W;

    logic [STB_N-1:0] stb_act, stb_act_d;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_eff;
    logic [DQ_W-1:0]  mask_q, rd_data, rd_q;
    logic             wr_en, drive_req;
    logic             ras_act, cas_act, we_act, oe_act;

    assign ras_act = stb_act[STB_RAS];
    assign cas_act = stb_act[STB_CAS];
    assign we_act  = stb_act[STB_WE];
    assign oe_act  = stb_act[STB_OE];

    strobe_sync #(.N(STB_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({oe_n, we_n, cas_n, ras_n}),
        .act    (stb_act),
        .act_d  (stb_act_d)
    );

    row_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (stb_act),
        .act_d     (stb_act_d),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .dq_in     (dq),
        .row_q     (row_q),
        .col_eff   (col_eff),
        .mask_q    (mask_q),
        .wr_en     (wr_en),
        .drive_req (drive_req)
    );

    word_array #(.AW(AW), .DQ_W(DQ_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_mask (mask_q),
        .addr    ({row_q, col_eff}),
        .wr_data (dq),
        .rd_data (rd_data)
    );

    // Output register: drive enable and read word, one clock behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_drv_en <= 1'b0;
            rd_q      <= '0;
        end else begin
            dq_drv_en <= drive_req;
            rd_q      <= rd_data;
        end
    end

    assign dq = dq_drv_en ? rd_q : {DQ_W{1'bz}};
endmodule

// File: rtl/mdram_io_chk.sv
// Protocol checker for mdram_io_ctrl, attached with bind.
// Assumes the synchronized strobe levels and internal controls are visible.
module mdram_io_chk #(
    parameter int DQ_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ras_act,
    input logic            cas_act,
    input logic            we_act,
    input logic            oe_act,
    input logic            wr_en,
    input logic            dq_drv_en,
    input logic [DQ_W-1:0] mask_q
);
    AST_DRIVE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drv_en |-> $past(ras_act && cas_act && oe_act && !we_act)); // R5
    AST_NO_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        we_act |=> !dq_drv_en); // R5
    AST_RELEASE_FIRST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_act || !oe_act) |=> !dq_drv_en); // R6
    AST_MASK_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_act && $past(!ras_act)) |-> (mask_q == {DQ_W{1'b1}})); // R3
    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ras_act && cas_act && we_act)); // R4
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4
endmodule

bind mdram_io_ctrl mdram_io_chk #(.DQ_W(DQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_act   (ras_act),
    .cas_act   (cas_act),
    .we_act    (we_act),
    .oe_act    (oe_act),
    .wr_en     (wr_en),
    .dq_drv_en (dq_drv_en),
    .mask_q    (mask_q)
);

// File: tb/mdram_io_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: full write and readback sweep, mask sweep, strobe-order and timing checks.
module mdram_io_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [3:0] row_addr = '0, col_addr = '0;
    logic [3:0] tb_dq = '0;
    logic       tb_en = 1'b0;
    wire  [3:0] dq;
    logic       dq_drv_en;
    int         tests = 0, fails = 0;
    bit         done = 1'b0;
    logic [3:0] model [16][16];

    assign dq = tb_en ? tb_dq : 4'bzzzz;

    always #2 clk = ~clk;

    mdram_io_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .row_addr(row_addr), .col_addr(col_addr), .dq(dq),
        .dq_drv_en(dq_drv_en)
    );

    task automatic chk(input string tag, input logic [3:0] actual, input logic [3:0] expected);
        tests++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic step();
        repeat (6) @(negedge clk);
    endtask

    // Masked write; order 0: column strobe falls first, 1: write enable first.
    task automatic do_write(input int r, input int c, input logic [3:0] m,
                            input logic [3:0] d, input bit order);
        tb_en = 1'b1; tb_dq = m; row_addr = 4'(r);
        step(); ras_n = 1'b0;
        step(); row_addr = ~4'(r); col_addr = 4'(c); tb_dq = ~d;
        if (!order) begin
            cas_n = 1'b0; step(); col_addr = ~4'(c); tb_dq = d;
            we_n = 1'b0; step();
        end else begin
            we_n = 1'b0; step(); tb_dq = d;
            cas_n = 1'b0; step(); col_addr = ~4'(c);
        end
        tb_dq = ~d; step();
        we_n = 1'b1; cas_n = 1'b1; step();
        ras_n = 1'b1; tb_en = 1'b0; step();
        model[r][c] = (model[r][c] & ~m) | (d & m);
    endtask

    // Read and release; rel 1: output enable rises first, 0: column strobe first.
    task automatic do_read(input int r, input int c, input bit rel, input string tag);
        tb_en = 1'b0; row_addr = 4'(r);
        step(); ras_n = 1'b0;
        step(); row_addr = ~4'(r); col_addr = 4'(c); cas_n = 1'b0;
        step(); col_addr = ~4'(c); oe_n = 1'b0;
        step();
        chk({tag, " R5 drive"}, {3'b0, dq_drv_en}, 4'h1);
        chk({tag, " R10 data"}, dq, model[r][c]);
        if (rel) begin
            oe_n = 1'b1; step();
            chk("R6 oe-first release", {3'b0, dq_drv_en}, 4'h0);
            cas_n = 1'b1;
        end else begin
            cas_n = 1'b1; step();
            chk("R6 cas-first release", {3'b0, dq_drv_en}, 4'h0);
            oe_n = 1'b1;
        end
        step(); ras_n = 1'b1; step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 reset drive", {3'b0, dq_drv_en}, 4'h0);
        rst_n = 1'b1;
        step();
        chk("R9 idle drive", {3'b0, dq_drv_en}, 4'h0);

        // R2 R4 R10: full-mask write of every location, both strobe orders.
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) begin
                model[r][c] = 4'h0;
                do_write(r, c, 4'hF, 4'((r * 3 + c * 5 + 1) & 15), 1'((r + c) & 1));
            end
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                do_read(r, c, 1'((r ^ c) & 1), "R4 sweep");

        // R2 R7: every mask value against fresh data.
        for (int m = 0; m < 16; m++) begin
            do_write(m, 15 - m, 4'(m), ~model[m][15 - m], 1'(m & 1));
            do_read(m, 15 - m, 1'b0, (m == 0) ? "R7 zero mask" : "R2 mask sweep");
        end

        // R1 R3: a zero-mask cycle, then a full-mask cycle on the same word.
        do_write(3, 3, 4'h0, 4'hA, 1'b0);
        do_read(3, 3, 1'b1, "R1 zero mask capture");
        do_write(3, 3, 4'hF, 4'hA, 1'b1);
        do_read(3, 3, 1'b0, "R3 fresh mask");

        // R8: exact latency from output-enable fall to pin drive.
        row_addr = 4'd5; step(); ras_n = 1'b0;
        step(); col_addr = 4'd6; cas_n = 1'b0; step();
        oe_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R8 not yet after two edges", {3'b0, dq_drv_en}, 4'h0);
        @(negedge clk);
        chk("R8 driven after third edge", {3'b0, dq_drv_en}, 4'h1);
        chk("R8 data", dq, model[5][6]);
        oe_n = 1'b1; cas_n = 1'b1; step(); ras_n = 1'b1; step();
        chk("R6 final release", {3'b0, dq_drv_en}, 4'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R5 watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule